// File: doc/BRIEF.md
# Processor Invalidate Forwarder with Stale-Line Cancellation

This block sits on the system side of a processor's bus. It takes an invalidate request from the local processor, holds it, and offers it to the system interconnect. While the request is still held and has not been taken by the interconnect, the block watches the invalidates that arrive from the rest of the system. If one of them names the same cache line, the processor's copy of the line is out of date. The held request is then withdrawn and never reaches the system. Instead, the block cancels it toward the processor.

Every invalidate that arrives from the system is passed on to the processor one cycle later. The cancellation travels on that same relayed request, as a qualifier flag. A request that the interconnect accepts finishes with one of two single-cycle pulses: an active-low acknowledge or an active-low error. Both sit on dedicated outputs and can coincide with relayed traffic. Each accepted request ends in exactly one of acknowledge, error or cancellation.

Top module: `inv_forwarder`

## Requirements
- R1: After a synchronous reset the block is idle. `busy` and `fwd_valid` are 0, `cmpl_ack_n` and `cmpl_err_n` are 1, and `ext_inv_valid` and `ext_inv_cancel` are 0.
- R2: A `proc_req_valid` in an idle cycle is accepted. From the next cycle, `busy` and `fwd_valid` are 1 and `fwd_addr` equals the accepted address. A `proc_req_valid` while `busy` is 1 is ignored, so `fwd_addr` keeps its value.
- R3: Two addresses name the same line when their bits [ADDR_W-1:LINE_OFF] are equal. The low LINE_OFF offset bits take no part in the compare.
- R4: A same-line `sys_inv_valid` while the request is held and unforwarded is a race. In the next cycle, `fwd_valid` is 0, `ext_inv_valid` and `ext_inv_cancel` are both 1, and neither completion output is low. One cycle later the block is idle.
- R5: When a race and `fwd_grant` occur in the same cycle, the race wins. The request is cancelled and no acknowledge or error follows.
- R6: An invalidate to a different line while the request is held is relayed with `ext_inv_cancel` at 0, and the request stays held with `fwd_valid` at 1.
- R7: `fwd_grant` while the request is held makes `fwd_valid` 0 from the next cycle. A same-line invalidate after that point does not cancel.
- R8: `sys_done` with `sys_fail` at 0 after forwarding drives `cmpl_ack_n` low for exactly the next cycle.
- R9: `sys_done` with `sys_fail` at 1 after forwarding drives `cmpl_err_n` low for exactly the next cycle.
- R10: At most one of acknowledge, error and cancel is active in any cycle. `busy` returns to 0 in the cycle after that completion.
- R11: Every `sys_inv_valid` appears one cycle later on `ext_inv_valid` with its address on `ext_inv_addr`, whatever the completion outputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_req_valid | input | 1 | Processor invalidate request strobe |
| proc_req_addr | input | ADDR_W | Address of the processor invalidate |
| busy | output | 1 | A request is being handled |
| fwd_valid | output | 1 | Held request offered to the system |
| fwd_addr | output | ADDR_W | Address of the held request |
| fwd_grant | input | 1 | System takes the offered request |
| sys_done | input | 1 | System completion of the forwarded request |
| sys_fail | input | 1 | Qualifies `sys_done` as failed |
| sys_inv_valid | input | 1 | Invalidate arriving from elsewhere in the system |
| sys_inv_addr | input | ADDR_W | Address of that invalidate |
| ext_inv_valid | output | 1 | Relayed invalidate toward the processor |
| ext_inv_addr | output | ADDR_W | Address of the relayed invalidate |
| ext_inv_cancel | output | 1 | Relayed invalidate also cancels the held request |
| cmpl_ack_n | output | 1 | Active-low acknowledge pulse |
| cmpl_err_n | output | 1 | Active-low error pulse |

## Verification
The assertions assume three things about the inputs. The system raises `fwd_grant` only while `fwd_valid` is offered. It raises `sys_done` only for a request it has taken. It holds `sys_fail` meaningful only together with `sys_done`. The stimulus drives each request through one fixed scenario, and it pulses grant and done only in the cycle after it has seen `fwd_valid` high or has granted. Extra processor strobes are driven only during busy cycles, to show they are ignored. The sweeps cover every offset within a line for same-line races, and neighbouring lines for non-matching invalidates.

// File: rtl/inv_fwd_pkg.sv
package inv_fwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HELD    = 3'd1,
    ST_SENT    = 3'd2,
    ST_ACK     = 3'd3,
    ST_ERR     = 3'd4,
    ST_CANCEL  = 3'd5
  } fwd_state_t;
endpackage

// File: rtl/line_match.sv
module line_match #(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFF = 4
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              same_line
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_OFF) - ADDR_W'(1));

  always_comb begin
    same_line = (((addr_a ^ addr_b) & LINE_MASK) == '0);
  end
endmodule

// File: rtl/inv_relay.sv
module inv_relay #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_cancel,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_cancel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_cancel <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_addr   <= in_valid ? in_addr : out_addr;
      out_cancel <= in_valid & in_cancel;
    end
  end

  // R11
  relay_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11
  relay_addr_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_addr == $past(in_addr)));
endmodule

// File: rtl/inv_fwd_fsm.sv
module inv_fwd_fsm
  import inv_fwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              grant,
  input  logic              done,
  input  logic              fail,
  input  logic              inv_valid,
  input  logic              inv_same_line,
  output logic              race,
  output logic              busy,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] held_addr,
  output logic              ack_n,
  output logic              err_n,
  output logic              cancel
);
  fwd_state_t state, state_nx;

  always_comb begin
    race = (state == ST_HELD) && inv_valid && inv_same_line;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (req_valid) state_nx = ST_HELD;
      ST_HELD:   if (race) state_nx = ST_CANCEL;
                 else if (grant) state_nx = ST_SENT;
      ST_SENT:   if (done) state_nx = fail ? ST_ERR : ST_ACK;
      ST_ACK, ST_ERR, ST_CANCEL: state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held_addr <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && req_valid) held_addr <= req_addr;
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    fwd_valid = (state == ST_HELD);
    ack_n     = (state != ST_ACK);
    err_n     = (state != ST_ERR);
    cancel    = (state == ST_CANCEL);
  end

  // R10
  one_completion_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~ack_n, ~err_n, cancel}));
  // R4
  race_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    race |=> (cancel && !fwd_valid));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> (ack_n && !busy));
  // R9
  err_after_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SENT && done && fail) |=> !err_n);
  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(held_addr));
endmodule

// File: rtl/inv_forwarder.sv
module inv_forwarder #(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_req_valid,
  input  logic [ADDR_W-1:0] proc_req_addr,
  output logic              busy,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_grant,
  input  logic              sys_done,
  input  logic              sys_fail,
  input  logic              sys_inv_valid,
  input  logic [ADDR_W-1:0] sys_inv_addr,
  output logic              ext_inv_valid,
  output logic [ADDR_W-1:0] ext_inv_addr,
  output logic              ext_inv_cancel,
  output logic              cmpl_ack_n,
  output logic              cmpl_err_n
);
  logic same_line;
  logic race;
  logic cancel_pulse;

  line_match #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_match (
    .addr_a    (fwd_addr),
    .addr_b    (sys_inv_addr),
    .same_line (same_line)
  );

  inv_fwd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (proc_req_valid),
    .req_addr      (proc_req_addr),
    .grant         (fwd_grant),
    .done          (sys_done),
    .fail          (sys_fail),
    .inv_valid     (sys_inv_valid),
    .inv_same_line (same_line),
    .race          (race),
    .busy          (busy),
    .fwd_valid     (fwd_valid),
    .held_addr     (fwd_addr),
    .ack_n         (cmpl_ack_n),
    .err_n         (cmpl_err_n),
    .cancel        (cancel_pulse)
  );

  inv_relay #(.ADDR_W(ADDR_W)) u_relay (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (sys_inv_valid),
    .in_addr    (sys_inv_addr),
    .in_cancel  (race),
    .out_valid  (ext_inv_valid),
    .out_addr   (ext_inv_addr),
    .out_cancel (ext_inv_cancel)
  );

  // R4
  cancel_rides_relay_chk: assert property (@(posedge clk) disable iff (rst)
    ext_inv_cancel |-> (ext_inv_valid && cancel_pulse));
  // R7
  no_cancel_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fwd_valid && cmpl_ack_n && cmpl_err_n && !cancel_pulse) |-> !ext_inv_cancel);
endmodule

// File: tb/inv_forwarder_test.sv
module inv_forwarder_test;
  localparam int AW  = 8;
  localparam int OFF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proc_req_valid = 1'b0;
  logic [AW-1:0] proc_req_addr = '0;
  logic fwd_grant = 1'b0, sys_done = 1'b0, sys_fail = 1'b0;
  logic sys_inv_valid = 1'b0;
  logic [AW-1:0] sys_inv_addr = '0;
  logic busy, fwd_valid, ext_inv_valid, ext_inv_cancel, cmpl_ack_n, cmpl_err_n;
  logic [AW-1:0] fwd_addr, ext_inv_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  inv_forwarder #(.ADDR_W(AW), .LINE_OFF(OFF)) uut (
    .clk(clk), .rst(rst),
    .proc_req_valid(proc_req_valid), .proc_req_addr(proc_req_addr),
    .busy(busy), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_grant(fwd_grant), .sys_done(sys_done), .sys_fail(sys_fail),
    .sys_inv_valid(sys_inv_valid), .sys_inv_addr(sys_inv_addr),
    .ext_inv_valid(ext_inv_valid), .ext_inv_addr(ext_inv_addr),
    .ext_inv_cancel(ext_inv_cancel),
    .cmpl_ack_n(cmpl_ack_n), .cmpl_err_n(cmpl_err_n)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    proc_req_valid = 1'b0; fwd_grant = 1'b0; sys_done = 1'b0;
    sys_fail = 1'b0; sys_inv_valid = 1'b0;
  endtask

  // kind: 0 race, 1 race with grant, 2 other line then ok, 3 same line after grant then ok, 4 fail
  task automatic run_req(input logic [AW-1:0] a, input logic [AW-1:0] ia, input int kind);
    @(negedge clk);
    proc_req_valid = 1'b1; proc_req_addr = a;
    @(negedge clk);
    clear_in();
    chk("R2 fwd_valid", AW'(fwd_valid), 1);
    chk("R2 fwd_addr", fwd_addr, a);
    chk("R2 busy", AW'(busy), 1);
    proc_req_valid = 1'b1; proc_req_addr = ~a;
    if (kind <= 1) begin
      sys_inv_valid = 1'b1; sys_inv_addr = ia;
      fwd_grant = (kind == 1);
      @(negedge clk);
      clear_in();
      chk("R4 cancel", AW'(ext_inv_cancel), 1);
      chk("R4 relay", AW'(ext_inv_valid), 1);
      chk("R11 relay addr", ext_inv_addr, ia);
      chk("R4 no fwd", AW'(fwd_valid), 0);
      chk("R5 no ack", AW'(cmpl_ack_n), 1);
      chk("R5 no err", AW'(cmpl_err_n), 1);
      chk("R2 ignored while busy", fwd_addr, a);
      @(negedge clk);
      chk("R10 idle after cancel", AW'(busy), 0);
      chk("R4 cancel single", AW'(ext_inv_cancel), 0);
    end else begin
      if (kind == 2) begin
        sys_inv_valid = 1'b1; sys_inv_addr = ia;
        @(negedge clk);
        clear_in();
        chk("R6 relay", AW'(ext_inv_valid), 1);
        chk("R6 no cancel", AW'(ext_inv_cancel), 0);
        chk("R6 still held", AW'(fwd_valid), 1);
        chk("R3 addr kept", fwd_addr, a);
      end
      fwd_grant = 1'b1;
      @(negedge clk);
      clear_in();
      chk("R7 fwd drop", AW'(fwd_valid), 0);
      chk("R7 busy", AW'(busy), 1);
      sys_done = 1'b1; sys_fail = (kind == 4);
      if (kind == 3) begin sys_inv_valid = 1'b1; sys_inv_addr = ia; end
      @(negedge clk);
      clear_in();
      if (kind == 4) begin
        chk("R9 err", AW'(cmpl_err_n), 0);
        chk("R10 no ack", AW'(cmpl_ack_n), 1);
      end else begin
        chk("R8 ack", AW'(cmpl_ack_n), 0);
        chk("R10 no err", AW'(cmpl_err_n), 1);
      end
      if (kind == 3) begin
        chk("R11 relay beside ack", AW'(ext_inv_valid), 1);
        chk("R7 no cancel after grant", AW'(ext_inv_cancel), 0);
      end
      @(negedge clk);
      chk("R8 pulse ends", AW'(cmpl_ack_n), 1);
      chk("R9 pulse ends", AW'(cmpl_err_n), 1);
      chk("R10 idle", AW'(busy), 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", AW'(busy), 0);
    chk("R1 fwd", AW'(fwd_valid), 0);
    chk("R1 ack", AW'(cmpl_ack_n), 1);
    chk("R1 err", AW'(cmpl_err_n), 1);
    chk("R1 ext", AW'(ext_inv_valid), 0);
    chk("R1 cancel", AW'(ext_inv_cancel), 0);
    rst = 1'b0;
    for (int ln = 0; ln < 4; ln++) begin
      for (int o = 0; o < (1 << OFF); o++) begin
        logic [AW-1:0] base;
        base = AW'((ln * 37 + 5) << OFF);
        // R3: any offset within the line races
        run_req(base, base | AW'(o), (o % 2));
        // R6: neighbouring line does not race
        run_req(base | AW'(o), base + AW'(1 << OFF), 2);
        run_req(base | AW'(o), base - AW'(1 << OFF) + AW'(o), 2);
      end
      run_req(base_of(ln), base_of(ln), 3);
      run_req(base_of(ln), base_of(ln), 4);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [AW-1:0] base_of(input int ln);
    return AW'((ln * 37 + 5) << OFF);
  endfunction
endmodule